// File: doc/BRIEF.md
# Edge-Pulse PWM Nibble Writer

This block turns a stream of 4-bit values into short active-low pulses on a disk drive's write-data line. The medium records only the falling edge of each pulse. Every value therefore becomes a pair of falling edges. The first edge opens the cycle. The second edge lands inside a one-microsecond window, and its position within that window encodes the value. With a 16 MHz tick, the window holds sixteen steps, one tick each.

A start strobe begins a stream. At that moment the block latches the number of sync cycles to send and the cycle-length mode. The sync cycles come first, and their edges are spaced further apart than any two data edges, so a reader can tell which edge opens a cycle. The data cycles follow. There are two length modes. In fixed mode every cycle lasts the same time. In variable mode the next cycle opens a set gap after the value edge. Values arrive on a valid/ready stream, and one value can wait in a single staging slot. If no value is waiting when a cycle ends, the line stays high and an underrun flag is raised until a value arrives.

Top module: `nibble_edge_writer`

## Requirements
- R1: After reset the write line is high, ready is low and the underrun flag is low.
- R2: Each data cycle gives exactly two falling edges. The value edge of value v falls 32 + v ticks after the start edge of the same cycle.
- R3: Every low pulse on the write line lasts exactly 4 ticks.
- R4: With a sync count N > 0, the first sync edge falls in the tick the start strobe is taken. N sync edges follow one another 64 ticks apart, and the first data start edge falls 64 ticks after the last sync edge.
- R5: With a sync count of 0, no sync edges are sent. The first data start edge falls in the tick after the first value is taken.
- R6: In fixed mode (mode input 1 at the start strobe) each data cycle lasts 79 ticks for every value: 32 + 15 + 32.
- R7: In variable mode (mode input 0 at the start strobe) the next start edge falls 32 ticks after the value edge, so a cycle of value v lasts 64 + v ticks.
- R8: Ready stays low from a data start edge through its value edge. It rises in the tick after the value edge if the staging slot is empty, and it is high during sync cycles and while waiting for data.
- R9: If no value is waiting when a cycle ends, the line stays high. The underrun flag is then high from the tick where the next start edge would have fallen. A value taken during underrun opens a cycle in the next tick and clears the flag.
- R10: The sync count and the mode inputs have no effect except in the tick the start strobe is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, nominally 16 MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start-of-stream strobe; latches the sync count and the mode |
| sync_count_i | input | SYNC_W | Number of sync cycles before the data |
| fixed_len_i | input | 1 | 1 = fixed cycle length, 0 = variable cycle length |
| nib_valid_i | input | 1 | A value is offered |
| nib_data_i | input | NIB_W | Value to encode |
| nib_ready_o | output | 1 | A value offered in this tick is taken |
| wr_n_o | output | 1 | Active-low write pulse line |
| underrun_o | output | 1 | No value was waiting when the last cycle ended |

## Verification
The write line is registered from the next-state values. A start edge therefore appears in the tick the strobe or the value is taken, or one tick later when the sync count is zero. The value edge follows 32 + v ticks after its start edge. Ready and the underrun flag are decoded from registered state, so each changes in the same tick as the edge that causes it. The bench records the line, ready and underrun in every tick after the start strobe, sampling on the falling clock edge. It then compares those records, tick by tick, against a list of expected edge times built from the requirements. During a run it also scrambles the sync count and mode inputs.

// File: rtl/nibwr_pkg.sv
package nibwr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_LEAD   = 3'd1,
    ST_SYNC   = 3'd2,
    ST_DATA   = 3'd3,
    ST_STARVE = 3'd4
  } wr_state_e;

endpackage

// File: rtl/nibwr_slot.sv
module nibwr_slot #(
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             accept_i,
  input  logic             launch_i,
  input  logic [NIB_W-1:0] data_i,
  output logic             full_o,
  output logic [NIB_W-1:0] val_o
);

  logic             full_d;
  logic             full_q;
  logic             load_en;
  logic [NIB_W-1:0] val_q;

  // Launch drains the slot. An accept that is not launched directly fills it.
  // A new stream empties the slot, unless a value is taken in that same tick.
  always_comb begin
    full_d  = full_q;
    load_en = 1'b0;
    if (launch_i) begin
      full_d = 1'b0;
    end else if (accept_i) begin
      full_d  = 1'b1;
      load_en = 1'b1;
    end else if (start_i) begin
      full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
    end else begin
      full_q <= full_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q <= '0;
    end else if (load_en) begin
      val_q <= data_i;
    end
  end

  assign full_o = full_q;
  assign val_o  = val_q;

endmodule

// File: rtl/nibwr_seq.sv
module nibwr_seq
  import nibwr_pkg::*;
#(
  parameter int NIB_W      = 4,
  parameter int LEAD_TICKS = 32,
  parameter int GAP_TICKS  = 32,
  parameter int SYNC_TICKS = 64,
  parameter int SYNC_W     = 4,
  parameter int CNT_W      = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [SYNC_W-1:0] sync_count_i,
  input  logic              fixed_len_i,
  input  logic              pend_full_i,
  input  logic [NIB_W-1:0]  pend_val_i,
  input  logic              accept_i,
  input  logic [NIB_W-1:0]  nib_data_i,
  output logic              launch_o,
  output logic              win_o,
  output logic              underrun_o,
  output wr_state_e         state_nx_o,
  output logic [CNT_W-1:0]  cnt_nx_o,
  output logic [NIB_W-1:0]  cur_nx_o
);

  localparam int STEPS   = 1 << NIB_W;
  localparam int FIX_LEN = LEAD_TICKS + STEPS - 1 + GAP_TICKS;
  localparam logic [CNT_W-1:0] SYNC_END = CNT_W'(SYNC_TICKS - 1);
  localparam logic [CNT_W-1:0] FIX_END  = CNT_W'(FIX_LEN - 1);
  localparam logic [CNT_W-1:0] LEAD_C   = CNT_W'(LEAD_TICKS);
  localparam logic [CNT_W-1:0] VAR_BASE = CNT_W'(LEAD_TICKS + GAP_TICKS - 1);
  localparam logic [SYNC_W-1:0] ONE_SYNC = SYNC_W'(1);

  wr_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [SYNC_W-1:0] left_q, left_d;
  logic [NIB_W-1:0]  cur_q, cur_d;
  logic              fixed_q, fixed_d;
  logic              launch;

  logic [CNT_W-1:0]  cur_ext;
  logic [CNT_W-1:0]  val_pos;
  logic [CNT_W-1:0]  cyc_end;
  logic              avail;
  logic [NIB_W-1:0]  new_val;

  assign cur_ext = CNT_W'(cur_q);
  assign val_pos = LEAD_C + cur_ext;
  assign cyc_end = fixed_q ? FIX_END : (VAR_BASE + cur_ext);
  assign avail   = pend_full_i | accept_i;
  assign new_val = pend_full_i ? pend_val_i : nib_data_i;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    left_d  = left_q;
    cur_d   = cur_q;
    fixed_d = fixed_q;
    launch  = 1'b0;
    if (state_q == ST_SYNC || state_q == ST_DATA) begin
      cnt_d = cnt_q + 1'b1;
    end
    if (start_i) begin
      fixed_d = fixed_len_i;
      cnt_d   = '0;
      left_d  = sync_count_i;
      state_d = (sync_count_i != '0) ? ST_SYNC : ST_LEAD;
    end else begin
      unique case (state_q)
        ST_LEAD, ST_STARVE: begin
          if (avail) begin
            state_d = ST_DATA;
            cnt_d   = '0;
            cur_d   = new_val;
            launch  = 1'b1;
          end
        end
        ST_SYNC: begin
          if (cnt_q == SYNC_END) begin
            cnt_d = '0;
            if (left_q != ONE_SYNC) begin
              left_d = left_q - 1'b1;
            end else if (avail) begin
              state_d = ST_DATA;
              cur_d   = new_val;
              launch  = 1'b1;
            end else begin
              state_d = ST_STARVE;
            end
          end
        end
        ST_DATA: begin
          if (cnt_q == cyc_end) begin
            cnt_d = '0;
            if (avail) begin
              cur_d  = new_val;
              launch = 1'b1;
            end else begin
              state_d = ST_STARVE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      left_q  <= '0;
      cur_q   <= '0;
      fixed_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      left_q  <= left_d;
      cur_q   <= cur_d;
      fixed_q <= fixed_d;
    end
  end

  assign win_o = (state_q == ST_LEAD) || (state_q == ST_STARVE) ||
                 (state_q == ST_SYNC) ||
                 ((state_q == ST_DATA) && (cnt_q > val_pos));
  assign underrun_o = (state_q == ST_STARVE);
  assign launch_o   = launch;
  assign state_nx_o = state_d;
  assign cnt_nx_o   = cnt_d;
  assign cur_nx_o   = cur_d;

endmodule

// File: rtl/nibwr_shaper.sv
module nibwr_shaper
  import nibwr_pkg::*;
#(
  parameter int NIB_W      = 4,
  parameter int LEAD_TICKS = 32,
  parameter int LOW_TICKS  = 4,
  parameter int CNT_W      = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wr_state_e        state_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [NIB_W-1:0] cur_i,
  output logic             wr_n_o
);

  localparam logic [CNT_W-1:0] LEAD_C = CNT_W'(LEAD_TICKS);
  localparam logic [CNT_W-1:0] LOW_C  = CNT_W'(LOW_TICKS);

  logic [CNT_W-1:0] val_pos;
  logic [CNT_W-1:0] val_end;
  logic             in_head;
  logic             in_val;
  logic             low_d;
  logic             wr_n_q;

  assign val_pos = LEAD_C + CNT_W'(cur_i);
  assign val_end = val_pos + LOW_C;
  assign in_head = (cnt_i < LOW_C);
  assign in_val  = (cnt_i >= val_pos) && (cnt_i < val_end);

  // Decode from next-state values so the registered line lines up with state.
  always_comb begin
    unique case (state_i)
      ST_SYNC: low_d = in_head;
      ST_DATA: low_d = in_head | in_val;
      default: low_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_n_q <= 1'b1;
    end else begin
      wr_n_q <= ~low_d;
    end
  end

  assign wr_n_o = wr_n_q;

endmodule

// File: rtl/nibble_edge_writer.sv
module nibble_edge_writer
  import nibwr_pkg::*;
#(
  parameter int NIB_W      = 4,
  parameter int LEAD_TICKS = 32,
  parameter int GAP_TICKS  = 32,
  parameter int SYNC_TICKS = 64,
  parameter int LOW_TICKS  = 4,
  parameter int SYNC_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [SYNC_W-1:0] sync_count_i,
  input  logic              fixed_len_i,
  input  logic              nib_valid_i,
  input  logic [NIB_W-1:0]  nib_data_i,
  output logic              nib_ready_o,
  output logic              wr_n_o,
  output logic              underrun_o
);

  localparam int FIX_LEN = LEAD_TICKS + (1 << NIB_W) - 1 + GAP_TICKS;
  localparam int MAX_LEN = (FIX_LEN > SYNC_TICKS) ? FIX_LEN : SYNC_TICKS;
  localparam int CNT_W   = $clog2(MAX_LEN);

  logic             pend_full;
  logic [NIB_W-1:0] pend_val;
  logic             accept;
  logic             launch;
  logic             win;
  wr_state_e        state_nx;
  logic [CNT_W-1:0] cnt_nx;
  logic [NIB_W-1:0] cur_nx;

  assign nib_ready_o = win & ~pend_full;
  assign accept      = nib_ready_o & nib_valid_i;

  nibwr_slot #(.NIB_W(NIB_W)) slot_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .accept_i (accept),
    .launch_i (launch),
    .data_i   (nib_data_i),
    .full_o   (pend_full),
    .val_o    (pend_val)
  );

  nibwr_seq #(
    .NIB_W      (NIB_W),
    .LEAD_TICKS (LEAD_TICKS),
    .GAP_TICKS  (GAP_TICKS),
    .SYNC_TICKS (SYNC_TICKS),
    .SYNC_W     (SYNC_W),
    .CNT_W      (CNT_W)
  ) seq_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .sync_count_i (sync_count_i),
    .fixed_len_i  (fixed_len_i),
    .pend_full_i  (pend_full),
    .pend_val_i   (pend_val),
    .accept_i     (accept),
    .nib_data_i   (nib_data_i),
    .launch_o     (launch),
    .win_o        (win),
    .underrun_o   (underrun_o),
    .state_nx_o   (state_nx),
    .cnt_nx_o     (cnt_nx),
    .cur_nx_o     (cur_nx)
  );

  nibwr_shaper #(
    .NIB_W      (NIB_W),
    .LEAD_TICKS (LEAD_TICKS),
    .LOW_TICKS  (LOW_TICKS),
    .CNT_W      (CNT_W)
  ) shaper_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .state_i (state_nx),
    .cnt_i   (cnt_nx),
    .cur_i   (cur_nx),
    .wr_n_o  (wr_n_o)
  );

endmodule

// File: rtl/nibwr_checker.sv
module nibwr_checker #(
  parameter int LOW_TICKS = 4,
  parameter int MIN_GAP   = 32
) (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic nib_valid_i,
  input logic nib_ready_o,
  input logic wr_n_o,
  input logic underrun_o
);

  logic       wr_prev;
  logic       fell;
  logic       seen;
  logic [7:0] gap_cnt;
  logic [7:0] low_cnt;

  assign fell = wr_prev & ~wr_n_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_prev <= 1'b1;
      seen    <= 1'b0;
      gap_cnt <= '0;
      low_cnt <= '0;
    end else begin
      wr_prev <= wr_n_o;
      seen    <= start_i ? 1'b0 : (seen | fell);
      gap_cnt <= fell ? 8'd0 : ((gap_cnt == 8'hFF) ? gap_cnt : gap_cnt + 8'd1);
      low_cnt <= wr_n_o ? 8'd0 : ((low_cnt == 8'hFF) ? low_cnt : low_cnt + 8'd1);
    end
  end

  // R3: a low pulse is never a single tick.
  assert_low_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_n_o) |=> !wr_n_o);

  // R3: a low pulse never runs past its width.
  assert_low_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n_o |-> (low_cnt < 8'(LOW_TICKS)));

  // R2: within a stream, falling edges keep at least the minimum spacing.
  assert_min_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fell && seen) |-> (gap_cnt >= 8'(MIN_GAP - 1)));

  // R9: the line is idle while starved.
  assert_starve_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_o |-> wr_n_o);

  // R8: a taken value closes ready in the following tick.
  assert_ready_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (nib_ready_o && nib_valid_i) |=> !nib_ready_o);

endmodule

bind nibble_edge_writer nibwr_checker #(
  .LOW_TICKS (LOW_TICKS),
  .MIN_GAP   ((LEAD_TICKS < GAP_TICKS) ? LEAD_TICKS : GAP_TICKS)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .nib_valid_i (nib_valid_i),
  .nib_ready_o (nib_ready_o),
  .wr_n_o      (wr_n_o),
  .underrun_o  (underrun_o)
);

// File: tb/nibble_edge_writer_tb.sv
`timescale 1ns/1ps
module nibble_edge_writer_tb_top;

  logic       clk;
  logic       rst_n;
  logic       start_i;
  logic [3:0] sync_count_i;
  logic       fixed_len_i;
  logic       nib_valid_i;
  logic [3:0] nib_data_i;
  logic       nib_ready_o;
  logic       wr_n_o;
  logic       underrun_o;

  nibble_edge_writer dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .sync_count_i (sync_count_i),
    .fixed_len_i  (fixed_len_i),
    .nib_valid_i  (nib_valid_i),
    .nib_data_i   (nib_data_i),
    .nib_ready_o  (nib_ready_o),
    .wr_n_o       (wr_n_o),
    .underrun_o   (underrun_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  int  q [0:63];
  int  qn;
  int  qi;
  bit  acc;
  logic wr_h [0:4095];
  logic rd_h [0:4095];
  logic ur_h [0:4095];
  logic wr_pre;
  int  ef [0:255];
  int  ek [0:255];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Expected waveform comes from edge list: low for 4 ticks from each fall.
  task automatic run_case(input bit do_start, input bit fx, input int ns);
    int t;
    int d;
    int nf;
    int last;
    int bad;
    int bad_at;
    nf = 0;
    t  = (do_start && ns == 0) ? 1 : 0;
    for (int i = 0; i < ns; i++) begin
      ef[nf] = t + 64 * i; ek[nf] = 0; nf++;
    end
    d = t + 64 * ns;
    for (int i = 0; i < qn; i++) begin
      ef[nf] = d;             ek[nf] = (i == 0 && do_start && ns == 0) ? 3 : 1; nf++;
      ef[nf] = d + 32 + q[i]; ek[nf] = 2; nf++;
      d += fx ? 79 : (64 + q[i]);
    end
    last = d + 12;

    qi = 0;
    @(negedge clk);
    wr_pre = wr_n_o;
    if (do_start) begin
      start_i      = 1'b1;
      fixed_len_i  = fx;
      sync_count_i = 4'(ns);
    end
    nib_valid_i = (qn > 0);
    nib_data_i  = 4'(q[0]);
    acc = nib_valid_i && nib_ready_o;
    for (int c = 0; c <= last; c++) begin
      @(negedge clk);
      wr_h[c] = wr_n_o;
      rd_h[c] = nib_ready_o;
      ur_h[c] = underrun_o;
      start_i      = 1'b0;
      fixed_len_i  = 1'($urandom);   // R10: ignored after the strobe
      sync_count_i = 4'($urandom);
      if (acc) qi++;
      nib_valid_i = (qi < qn);
      nib_data_i  = 4'(q[(qi < qn) ? qi : 0]);
      acc = nib_valid_i && nib_ready_o;
    end
    nib_valid_i = 1'b0;

    for (int k = 0; k < nf; k++) begin
      logic pv;
      bit   ok;
      pv = (ef[k] == 0) ? wr_pre : wr_h[ef[k] - 1];
      ok = (pv === 1'b1) && (wr_h[ef[k]] === 1'b0);
      case (ek[k])
        0: chk(ok, "R4", "sync edge at tick", int'(wr_h[ef[k]]), 0);
        1: chk(ok, fx ? "R6" : "R7", "start edge at tick", int'(wr_h[ef[k]]), 0);
        3: chk(ok, "R5", "first start edge without sync", int'(wr_h[ef[k]]), 0);
        default: begin
          chk(ok, "R2", "value edge at tick", int'(wr_h[ef[k]]), 0);
          chk(rd_h[ef[k]] === 1'b0 && rd_h[ef[k] + 1] === 1'b1, "R8",
              "ready low at value edge then high",
              int'(rd_h[ef[k]]) * 2 + int'(rd_h[ef[k] + 1]), 1);
        end
      endcase
    end

    bad = 0; bad_at = -1;
    for (int c = 0; c <= last; c++) begin
      logic ew;
      ew = 1'b1;
      for (int k = 0; k < nf; k++) begin
        if (c >= ef[k] && c < ef[k] + 4) ew = 1'b0;
      end
      if (wr_h[c] !== ew) begin bad++; if (bad_at < 0) bad_at = c; end
    end
    chk(bad == 0, "R3 R10", "waveform mismatches (first at tick)", bad_at, -1);

    bad = 0; bad_at = -1;
    for (int c = 0; c <= last; c++) begin
      if (ur_h[c] !== (c >= d)) begin bad++; if (bad_at < 0) bad_at = c; end
    end
    chk(bad == 0, "R9", "underrun mismatch (first at tick)", bad_at, -1);
  endtask

  initial begin
    rst_n        = 1'b0;
    start_i      = 1'b0;
    sync_count_i = '0;
    fixed_len_i  = 1'b0;
    nib_valid_i  = 1'b0;
    nib_data_i   = '0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle after reset
    chk(wr_n_o === 1'b1, "R1", "write line after reset", int'(wr_n_o), 1);
    chk(nib_ready_o === 1'b0, "R1", "ready after reset", int'(nib_ready_o), 0);
    chk(underrun_o === 1'b0, "R1", "underrun after reset", int'(underrun_o), 0);

    // fixed mode, sync 3, corner values then random
    q[0] = 0; q[1] = 15;
    for (int i = 2; i < 10; i++) q[i] = int'($urandom_range(15, 0));
    qn = 10;
    run_case(1'b1, 1'b1, 3);

    // variable mode, sync 2
    q[0] = 15; q[1] = 0;
    for (int i = 2; i < 10; i++) q[i] = int'($urandom_range(15, 0));
    qn = 10;
    run_case(1'b1, 1'b0, 2);

    // R5: no sync, variable then fixed
    for (int i = 0; i < 5; i++) q[i] = int'($urandom_range(15, 0));
    qn = 5;
    run_case(1'b1, 1'b0, 0);
    for (int i = 0; i < 3; i++) q[i] = int'($urandom_range(15, 0));
    qn = 3;
    run_case(1'b1, 1'b1, 0);

    // R9: resume from underrun without a new strobe (fixed mode still held)
    q[0] = 15; qn = 1;
    run_case(1'b0, 1'b1, 0);
    q[0] = 0; qn = 1;
    run_case(1'b0, 1'b1, 0);

    // sync run with no data behind it
    qn = 0;
    run_case(1'b1, 1'b0, 2);

    // random streams
    for (int r = 0; r < 4; r++) begin
      int ns;
      bit fx;
      ns = int'($urandom_range(4, 0));
      fx = 1'($urandom);
      qn = int'($urandom_range(6, 1));
      for (int i = 0; i < qn; i++) q[i] = int'($urandom_range(15, 0));
      run_case(1'b1, fx, ns);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R9 watchdog expired: actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule